// File: doc/BRIEF.md
# Single-Bus Datapath Under Nano-Instruction Control

This block is a datapath built around one shared main bus. An external data input, a register file with two read ports, an ALU followed by a shift stage, an accumulator-style M register and a small memory all sit on that bus. In any cycle at most one of them drives it. A flat control word sets every unit directly each cycle. Its fields are the bus-source enables, two read addresses, a write address and write strobe, an ALU operation, a shift code, an M-register load strobe, a memory address and a memory write strobe. No decoder sits between that word and the hardware.

The bus is combinational from the control word. Every state change happens on the rising clock edge and uses the values present during that cycle: register-file and memory writes take the bus, and the M register takes the shifter output. A sequencer outside the block supplies one control word per cycle. It moves data by choosing one source and one or more destinations, and it keeps every other strobe low so that nothing else changes.

Top module: `dp_nano_datapath`

## Requirements
- R1: The bus-source enable vector is one-hot by position: bit 0 the data input, bit 1 register-file read port 1, bit 2 the ALU/shift result, bit 3 the M register, bit 4 the memory read data. With exactly one bit set, the bus carries that source in the same cycle.
- R2: With no enable bit set, the bus is zero and the error output is low. With two or more enable bits set, the bus is zero and the error output is high.
- R3: When the register-file write strobe is high, the register at the write address takes the bus value on the rising edge. When it is low, no register changes.
- R4: Read port 1 and read port 2 each select any register on their own. Port 1 feeds ALU operand A and the bus source, and port 2 feeds ALU operand B.
- R5: ALU operation codes: 000 gives A, 001 gives B, 010 gives all zeros, 011 gives all ones, 100 gives A+B modulo 2^n, 101 gives A-B modulo 2^n, 110 gives A AND B, 111 gives A OR B.
- R6: Shift codes act on the ALU result. 00 passes it unchanged. 01 shifts left one place, filling bit 0 from the M register's top bit. 10 shifts right one place, filling the top bit from the M register's bit 0. 11 shifts left one place, filling with zero.
- R7: When the M-load strobe is high, the M register takes the shift-stage output on the rising edge. Otherwise it holds.
- R8: Memory reads are combinational from the memory address. When the memory write strobe is high, the addressed word takes the bus value on the rising edge.
- R9: Reset clears every register-file entry, the M register and every memory word to zero.
- R10: A write issued in a cycle with a bus conflict stores zero, because it stores the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DW | External data input |
| src_en | input | 5 | Bus-source enables, one bit per source |
| ra1 | input | log2(NREGS) | Read port 1 address |
| ra2 | input | log2(NREGS) | Read port 2 address |
| wa | input | log2(NREGS) | Register-file write address |
| wr | input | 1 | Register-file write strobe |
| alu_op | input | 3 | ALU operation code |
| shift_code | input | 2 | Shift-stage code |
| ldm | input | 1 | M-register load strobe |
| mem_addr | input | log2(MEM_DEPTH) | Memory address |
| wm | input | 1 | Memory write strobe |
| bus | output | DW | Main bus value |
| bus_err | output | 1 | More than one bus source enabled |

## Verification
The bus and the error flag are combinational, so they are due in the same cycle as the control word. The bench drives each word just after a falling edge and samples a quarter period later, before the next rising edge. Register-file, memory and M-register results appear one edge later. The bench reads them back through the bus in the step that follows the writing step, and its own model of the state is updated only after the comparison for the current step has been made.

// File: rtl/dp_pkg.sv
package dp_pkg;

  localparam int NSRC     = 5;
  localparam int SRC_IN   = 0;
  localparam int SRC_RF   = 1;
  localparam int SRC_ALU  = 2;
  localparam int SRC_M    = 3;
  localparam int SRC_MEM  = 4;

  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000,
    OP_PASS_B = 3'b001,
    OP_ZERO   = 3'b010,
    OP_ONES   = 3'b011,
    OP_ADD    = 3'b100,
    OP_SUB    = 3'b101,
    OP_AND    = 3'b110,
    OP_OR     = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_LEFT_M = 2'b01,
    SH_RIGHT_M= 2'b10,
    SH_LEFT_0 = 2'b11
  } shift_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] regs [NREGS];

  // One write port, generated per entry so each register has its own enable.
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = we && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wr_data;
    end
  end

  // Two independent NREGS-to-1 read multiplexers.
  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

endmodule

// File: rtl/dp_memory.sv
module dp_memory #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = we && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[g] <= '0;
      else if (sel) words[g] <= wdata;
    end
  end

  // Combinational read so memory data can reach the bus in the same cycle.
  assign rdata = words[addr];

endmodule

// File: rtl/dp_alu_shift.sv
module dp_alu_shift
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] m_val,
  input  logic [2:0]    op,
  input  logic [1:0]    sh,
  output logic [DW-1:0] alu_y,
  output logic [DW-1:0] result
);

  function automatic logic [DW-1:0] alu_fn(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input alu_op_e        code);
    case (code)
      OP_PASS_A: return a;
      OP_PASS_B: return b;
      OP_ZERO:   return '0;
      OP_ONES:   return '1;
      OP_ADD:    return a + b;
      OP_SUB:    return a - b;
      OP_AND:    return a & b;
      default:   return a | b;
    endcase
  endfunction

  function automatic logic [DW-1:0] shift_fn(input logic [DW-1:0] v,
                                             input logic [DW-1:0] m,
                                             input shift_e         code);
    case (code)
      SH_NONE:    return v;
      SH_LEFT_M:  return {v[DW-2:0], m[DW-1]};
      SH_RIGHT_M: return {m[0], v[DW-1:1]};
      default:    return {v[DW-2:0], 1'b0};
    endcase
  endfunction

  assign alu_y  = alu_fn(opa, opb, alu_op_e'(op));
  assign result = shift_fn(alu_y, m_val, shift_e'(sh));

endmodule

// File: rtl/dp_bus_mux.sv
module dp_bus_mux
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NSRC-1:0]         en,
  input  logic [NSRC-1:0][DW-1:0] srcs,
  output logic [DW-1:0]           bus,
  output logic                    conflict
);

  logic [NSRC-1:0][DW-1:0] gated;
  logic [DW-1:0]           merged;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = srcs[g] & {DW{en[g]}};
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NSRC; i++) merged |= gated[i];
  end

  // Clearing the lowest set bit leaves something only when two or more are set.
  assign conflict = |(en & (en - NSRC'(1)));
  assign bus      = conflict ? '0 : merged;

endmodule

// File: rtl/dp_nano_datapath.sv
module dp_nano_datapath
  import dp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NREGS     = 8,
  parameter int MEM_DEPTH = 16,
  localparam int RAW      = $clog2(NREGS),
  localparam int MAW      = $clog2(MEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   din,
  input  logic [NSRC-1:0] src_en,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  input  logic [RAW-1:0]  wa,
  input  logic            wr,
  input  logic [2:0]      alu_op,
  input  logic [1:0]      shift_code,
  input  logic            ldm,
  input  logic [MAW-1:0]  mem_addr,
  input  logic            wm,
  output logic [DW-1:0]   bus,
  output logic            bus_err
);

  // Named internal events, brought out for the checker.
  logic [DW-1:0] rf_a, rf_b;
  logic [DW-1:0] alu_y, shift_y;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] m_q;
  logic          rf_we, mem_we, m_load;
  logic [NSRC-1:0][DW-1:0] bus_srcs;

  assign rf_we  = wr;
  assign mem_we = wm;
  assign m_load = ldm;

  dp_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (ra1),
    .rd_addr_b (ra2),
    .rd_data_a (rf_a),
    .rd_data_b (rf_b),
    .we        (rf_we),
    .wr_addr   (wa),
    .wr_data   (bus)
  );

  dp_alu_shift #(.DW(DW)) u_alu (
    .opa    (rf_a),
    .opb    (rf_b),
    .m_val  (m_q),
    .op     (alu_op),
    .sh     (shift_code),
    .alu_y  (alu_y),
    .result (shift_y)
  );

  dp_memory #(.DW(DW), .DEPTH(MEM_DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (mem_addr),
    .we    (mem_we),
    .wdata (bus),
    .rdata (mem_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      m_q <= '0;
    else if (m_load) m_q <= shift_y;
  end

  assign bus_srcs[SRC_IN]  = din;
  assign bus_srcs[SRC_RF]  = rf_a;
  assign bus_srcs[SRC_ALU] = shift_y;
  assign bus_srcs[SRC_M]   = m_q;
  assign bus_srcs[SRC_MEM] = mem_q;

  dp_bus_mux #(.DW(DW)) u_bus (
    .en       (src_en),
    .srcs     (bus_srcs),
    .bus      (bus),
    .conflict (bus_err)
  );

endmodule

// File: rtl/dp_nano_datapath_chk.sv
module dp_nano_datapath_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    src_en,
  input logic [DW-1:0] din,
  input logic [2:0]    alu_op,
  input logic [1:0]    shift_code,
  input logic          ldm,
  input logic [DW-1:0] alu_y,
  input logic [DW-1:0] shift_y,
  input logic [DW-1:0] m_q,
  input logic [DW-1:0] bus,
  input logic          bus_err
);

  assert_input_on_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == 5'b00001) |-> (bus == din));

  assert_conflict_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot0(src_en) |-> bus_err);

  assert_conflict_zero_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus == '0));

  assert_zero_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'b010) |-> (alu_y == '0));

  assert_shift_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_code == 2'b00) |-> (shift_y == alu_y));

  assert_m_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ldm |=> $stable(m_q));

  assert_m_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ldm |=> (m_q == $past(shift_y)));

endmodule

bind dp_nano_datapath dp_nano_datapath_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_en     (src_en),
  .din        (din),
  .alu_op     (alu_op),
  .shift_code (shift_code),
  .ldm        (ldm),
  .alu_y      (alu_y),
  .shift_y    (shift_y),
  .m_q        (m_q),
  .bus        (bus),
  .bus_err    (bus_err)
);

// File: tb/tb_dp_nano_datapath.sv
module tb_dp_nano_datapath;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NREGS = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    din = '0;
  logic [4:0]    src_en = '0;
  logic [2:0]    ra1 = '0, ra2 = '0, wa = '0;
  logic          wr = 1'b0;
  logic [2:0]    alu_op = '0;
  logic [1:0]    shift_code = '0;
  logic          ldm = 1'b0;
  logic [3:0]    mem_addr = '0;
  logic          wm = 1'b0;
  logic [7:0]    bus;
  logic          bus_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_nano_datapath #(.DW(DW), .NREGS(NREGS), .MEM_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .src_en(src_en),
    .ra1(ra1), .ra2(ra2), .wa(wa), .wr(wr), .alu_op(alu_op),
    .shift_code(shift_code), .ldm(ldm), .mem_addr(mem_addr), .wm(wm),
    .bus(bus), .bus_err(bus_err)
  );

  // Bench model of the visible state.
  logic [7:0] mdl_rf  [NREGS];
  logic [7:0] mdl_mem [DEPTH];
  logic [7:0] mdl_m;

  typedef struct packed {
    logic [4:0] src;
    logic [2:0] r1, r2, w;
    logic       wr;
    logic [2:0] op;
    logic [1:0] sh;
    logic       ldm;
    logic [3:0] ad;
    logic       wm;
    logic [7:0] d;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 26;
  localparam step_t STEPS [NSTEP] = '{
    // src     r1    r2    w     wr   op    sh     ldm  ad     wm   d       req
    '{5'b00001,3'd0,3'd0,3'd1,1'b1,3'd0,2'b00,1'b0,4'd0,1'b0,8'h3C,4'd1}, // R1 input -> r1
    '{5'b00001,3'd0,3'd0,3'd2,1'b1,3'd0,2'b00,1'b0,4'd0,1'b0,8'hA5,4'd3}, // R3
    '{5'b00001,3'd0,3'd0,3'd7,1'b1,3'd0,2'b00,1'b0,4'd0,1'b0,8'h01,4'd3},
    '{5'b00010,3'd2,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h00,4'd4}, // R4 port1 on bus
    '{5'b00100,3'd1,3'd2,3'd3,1'b1,3'd4,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5}, // R5 add
    '{5'b00100,3'd1,3'd2,3'd0,1'b0,3'd5,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5}, // R5 sub
    '{5'b00100,3'd1,3'd2,3'd0,1'b0,3'd6,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5}, // R5 and
    '{5'b00100,3'd1,3'd2,3'd0,1'b0,3'd7,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5}, // R5 or
    '{5'b00100,3'd1,3'd7,3'd0,1'b0,3'd1,2'b00,1'b0,4'd0,1'b0,8'h00,4'd4}, // R4 port2
    '{5'b00100,3'd1,3'd7,3'd0,1'b0,3'd2,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5},
    '{5'b00100,3'd1,3'd7,3'd0,1'b0,3'd3,2'b00,1'b0,4'd0,1'b0,8'h00,4'd5},
    '{5'b00010,3'd3,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h00,4'd3}, // R3 sum stored
    '{5'b00100,3'd2,3'd0,3'd0,1'b0,3'd0,2'b11,1'b1,4'd0,1'b0,8'h00,4'd6}, // R6 left zero, load M
    '{5'b01000,3'd0,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h00,4'd7}, // R7 M on bus
    '{5'b00100,3'd1,3'd0,3'd0,1'b0,3'd0,2'b01,1'b0,4'd0,1'b0,8'h00,4'd6}, // R6 left with M
    '{5'b00100,3'd0,3'd0,3'd0,1'b0,3'd3,2'b00,1'b1,4'd0,1'b0,8'h00,4'd7}, // R7 M <- ones
    '{5'b00100,3'd1,3'd0,3'd0,1'b0,3'd0,2'b01,1'b0,4'd0,1'b0,8'h00,4'd6},
    '{5'b00100,3'd1,3'd0,3'd0,1'b0,3'd0,2'b10,1'b0,4'd0,1'b0,8'h00,4'd6}, // R6 right with M
    '{5'b01000,3'd0,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h00,4'd7}, // R7 hold
    '{5'b00001,3'd0,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd9,1'b1,8'h5A,4'd8}, // R8 write mem
    '{5'b10000,3'd0,3'd0,3'd4,1'b1,3'd0,2'b00,1'b0,4'd9,1'b0,8'h00,4'd8}, // R8 read mem -> r4
    '{5'b00010,3'd4,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd3,1'b0,8'h00,4'd8},
    '{5'b00001,3'd0,3'd0,3'd5,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h77,4'd3}, // R3 no strobe
    '{5'b00010,3'd5,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'h00,4'd3},
    '{5'b00000,3'd0,3'd0,3'd0,1'b0,3'd0,2'b00,1'b0,4'd0,1'b0,8'hEE,4'd2}, // R2 idle bus
    '{5'b00011,3'd1,3'd0,3'd1,1'b1,3'd0,2'b00,1'b0,4'd0,1'b0,8'hEE,4'd10} // R10 conflict write
  };

  function automatic logic [7:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] op);
    logic [7:0] r;
    if (op[2] == 1'b0) begin
      r = (op[1:0] == 2'd0) ? a : (op[1:0] == 2'd1) ? b :
          (op[1:0] == 2'd2) ? 8'h00 : 8'hFF;
    end else begin
      r = (op[1:0] == 2'd0) ? 8'(a + b) : (op[1:0] == 2'd1) ? 8'(a + ~b + 8'd1) :
          (op[1:0] == 2'd2) ? (a & b) : (a | b);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_shift(input logic [7:0] v, input logic [7:0] m,
                                           input logic [1:0] sh);
    logic [8:0] t;
    if (sh == 2'b00) return v;
    if (sh == 2'b10) return (v >> 1) | (m[0] ? 8'h80 : 8'h00);
    t = {v, 1'b0};
    if (sh == 2'b01) t[0] = m[7];
    return t[7:0];
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREGS; i++) mdl_rf[i] = '0;
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
    mdl_m = '0;
  endtask

  task automatic idle();
    src_en = '0; wr = 0; wm = 0; ldm = 0;
  endtask

  task automatic run_step(input step_t s);
    logic [7:0] alu_v, exp_bus;
    int cnt;
    @(negedge clk);
    src_en = s.src; ra1 = s.r1; ra2 = s.r2; wa = s.w; wr = s.wr;
    alu_op = s.op; shift_code = s.sh; ldm = s.ldm; mem_addr = s.ad;
    wm = s.wm; din = s.d;
    #(CLK_PERIOD/4);
    alu_v = ref_shift(ref_alu(mdl_rf[s.r1], mdl_rf[s.r2], s.op), mdl_m, s.sh);
    cnt = 0;
    for (int i = 0; i < 5; i++) cnt += int'(s.src[i]);
    exp_bus = 8'h00;
    if (cnt == 1) begin
      if (s.src[0]) exp_bus = s.d;
      if (s.src[1]) exp_bus = mdl_rf[s.r1];
      if (s.src[2]) exp_bus = alu_v;
      if (s.src[3]) exp_bus = mdl_m;
      if (s.src[4]) exp_bus = mdl_mem[s.ad];
    end
    check($sformatf("R%0d bus", s.req), bus, exp_bus);
    check($sformatf("R%0d err", s.req), {7'd0, bus_err}, {7'd0, cnt > 1});
    if (s.wr)  mdl_rf[s.w]   = exp_bus;
    if (s.wm)  mdl_mem[s.ad] = exp_bus;
    if (s.ldm) mdl_m         = alu_v;
  endtask

  function automatic step_t rd(input logic [4:0] src, input logic [2:0] r,
                               input logic [3:0] ad, input logic [3:0] req);
    step_t s = '0;
    s.src = src; s.r1 = r; s.ad = ad; s.req = req;
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: state after reset reads zero through the bus
    run_step(rd(5'b00010, 3'd6, 4'd0, 4'd9));
    run_step(rd(5'b01000, 3'd0, 4'd0, 4'd9));
    run_step(rd(5'b10000, 3'd0, 4'd15, 4'd9));

    for (int k = 0; k < NSTEP; k++) run_step(STEPS[k]);

    // R10: register 1 holds zero after the conflicting write
    run_step(rd(5'b00010, 3'd1, 4'd0, 4'd10));
    // R2: all five sources at once
    run_step(rd(5'b11111, 3'd2, 4'd9, 4'd2));
    // R1: memory and M as sole sources
    run_step(rd(5'b10000, 3'd0, 4'd9, 4'd1));
    run_step(rd(5'b01000, 3'd0, 4'd0, 4'd1));

    // R9: reset in mid-run clears written state
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    run_step(rd(5'b00010, 3'd2, 4'd0, 4'd9));
    run_step(rd(5'b00010, 3'd4, 4'd0, 4'd9));
    run_step(rd(5'b01000, 3'd0, 4'd0, 4'd9));
    run_step(rd(5'b10000, 3'd0, 4'd9, 4'd9));

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule